// File: doc/BRIEF.md
# CCD horizontal shift clock and blanking generator

This block produces the horizontal timing for one line of a CCD readout: a horizontal blanking level and two shift-clock outputs in opposite phase. The first output drives the odd-numbered shift gates and the second drives the even-numbered ones. The block runs on a clock at twice the pixel rate, so every pixel lasts two clock ticks. A pixel counter runs from 0 up to the programmed line length minus one and then starts the next line.

The blanking level is not a single window. Up to six programmable positions each invert it when the pixel counter reaches them, so one line can carry several separate blanking pulses. While blanking is active, the shift clocks can be slowed by an even divisor from a 3-bit code, which widens their pulses. Outside blanking they always run at the pixel rate.

Settings are written through a small parallel port. Each setting is first held in a staging copy. The staging copy moves into the working copy only at the start of the next line, so a change made partway through a line never affects that line.

Top module: `hclk_blank_gen`

## Requirements
- R1: A synchronous active-low reset makes the outputs blanking = 0, odd shift clock = 0 and even shift clock = 1 from the clock edge that samples reset low. The pixel counter goes to 0. Every staged and working setting returns to its default: toggle positions all ones, line length DEF_LEN, rate code 0.
- R2: Each pixel lasts two clock ticks, and the first tick after reset is the first half of pixel 0. A line has L pixels, numbered 0 to L-1. A programmed line length below 2 is treated as 2.
- R3: During pixel c the blanking level equals the parity of the number of valid toggle positions p with p <= c. Each valid position inverts the level for the pixels from p onward.
- R4: A toggle position at or beyond the effective line length has no effect on the blanking level. This includes the all-ones value used to mark an unused slot. Two equal positions cancel each other.
- R5: Blanking is inactive at the start of every line unless a toggle position of 0 is programmed. A blanking pulse that reaches pixel L-1 ends at the line wrap.
- R6: The even shift clock is always the inverse of the odd shift clock.
- R7: When blanking is inactive, or the rate code is 0, the odd shift clock is low in the first tick of each pixel and high in the second tick.
- R8: When blanking is active and the rate code n is from 1 to 7, the odd shift clock has a period of 2n pixels. It is low for n pixels and then high for n pixels, and holds its level for both ticks of each pixel. The phase restarts low at the first pixel of each blanking pulse and at pixel 0 of each line.
- R9: A write with cfg_we high stores cfg_wdata into a staged setting chosen by cfg_addr. Addresses 0 to 5 select toggle positions 1 to 6, address 6 selects the line length, and address 7 selects the rate code, taken from the low 3 data bits. The staged values become active together at the next line start. A write accepted at the final clock edge of a line takes effect one line later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 3 | Setting select (0-5 toggle, 6 length, 7 rate code) |
| cfg_wdata | input | 10 | Setting write value |
| hblank_o | output | 1 | Horizontal blanking level, active high |
| h13_o | output | 1 | Odd-gate horizontal shift clock |
| h24_o | output | 1 | Even-gate horizontal shift clock, inverse phase |

## Verification
A pixel counter that is off by one, or a length that is applied at the wrong time, moves every later blanking edge. A wrong blanking level then shows at the ports within one pixel of the misplaced toggle point. A divider phase that is not restarted, or a wrong terminal count, makes the slowed shift clock depart from its 2n-pixel pattern within one divided period of the start of the pulse. A setting that becomes active early corrupts the line in which it was written, which shows at the ports before the next wrap. The bench therefore compares all three outputs on every tick against a line model for random lengths, positions and rate codes.

// File: rtl/hblk_pkg.sv
// Shared definitions for the horizontal clock and blanking generator.
// Assumes: settings use an address map of toggle slots, then length, then code.
package hblk_pkg;

    // Smallest line length the pixel counter will run with.
    localparam int unsigned MIN_LINE = 2;

    // Kind of setting selected by a configuration address.
    typedef enum logic [1:0] {
        SEL_TOG  = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_CODE = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/hblk_cfg_regs.sv
// Staged and working copies of the line settings.
// Writes land in the staged copy; the whole staged copy moves into the
// working copy on the line-end strobe, so a line only ever sees one set.
// Assumes: load is a single-cycle pulse on the last tick of a line.
module hblk_cfg_regs
    import hblk_pkg::*;
#(
    parameter int unsigned CNT_W   = 10,
    parameter int unsigned NUM_TOG = 6,
    parameter int unsigned CODE_W  = 3,
    parameter int unsigned DEF_LEN = 16,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [CNT_W-1:0]                wdata,
    input  logic                            load,
    output logic [NUM_TOG-1:0][CNT_W-1:0]   stg_pos,
    output logic [CNT_W-1:0]                stg_len,
    output logic [NUM_TOG-1:0][CNT_W-1:0]   act_pos,
    output logic [CNT_W-1:0]                act_len,
    output logic [CODE_W-1:0]               act_code
);

    localparam logic [ADDR_W-1:0] LEN_ADDR  = ADDR_W'(NUM_TOG);
    localparam logic [ADDR_W-1:0] CODE_ADDR = ADDR_W'(NUM_TOG + 1);

    cfg_sel_e           sel;
    logic [CODE_W-1:0]  stg_code;

    // Decode the address into the kind of setting it targets.
    always_comb begin
        if (addr < LEN_ADDR)        sel = SEL_TOG;
        else if (addr == LEN_ADDR)  sel = SEL_LEN;
        else if (addr == CODE_ADDR) sel = SEL_CODE;
        else                        sel = SEL_NONE;
    end

    // One staged and one working register per toggle slot.
    for (genvar k = 0; k < NUM_TOG; k++) begin : g_slot
        // Staged toggle position, written through the setting port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg_pos[k] <= '1;
            else if (we && sel == SEL_TOG && addr == ADDR_W'(k))
                stg_pos[k] <= wdata;
        end

        // Working toggle position, refreshed at line end.
        always_ff @(posedge clk) begin
            if (!rst_n)    act_pos[k] <= '1;
            else if (load) act_pos[k] <= stg_pos[k];
        end
    end

    // Staged line length and rate code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_len  <= CNT_W'(DEF_LEN);
            stg_code <= '0;
        end else if (we) begin
            if (sel == SEL_LEN)  stg_len  <= wdata;
            if (sel == SEL_CODE) stg_code <= wdata[CODE_W-1:0];
        end
    end

    // Working line length and rate code, refreshed at line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_len  <= CNT_W'(DEF_LEN);
            act_code <= '0;
        end else if (load) begin
            act_len  <= stg_len;
            act_code <= stg_code;
        end
    end

endmodule

// File: rtl/hblk_pix_timer.sv
// Pixel timing: a half-pixel phase bit and the pixel counter for one line.
// Assumes: clk runs at twice the pixel rate; ph = 0 marks the first half.
module hblk_pix_timer
    import hblk_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] act_len,
    output logic             ph,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             line_end
);

    logic [CNT_W-1:0] len_eff;

    // Clamp the line length to the smallest usable value.
    always_comb len_eff = (act_len < CNT_W'(MIN_LINE)) ? CNT_W'(MIN_LINE) : act_len;

    // Detect the last tick of the line and form the next pixel number.
    always_comb begin
        line_end = ph && (cnt == len_eff - 1'b1);
        cnt_nxt  = line_end ? '0 : cnt + 1'b1;
    end

    // Advance the phase every tick and the pixel at each pixel boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= 1'b0;
            cnt <= '0;
        end else begin
            ph <= ~ph;
            if (ph) cnt <= cnt_nxt;
        end
    end

endmodule

// File: rtl/hblk_blank_gen.sv
// Compound blanking level from several toggle positions.
// Each valid position that equals the coming pixel number inverts the level;
// at the line wrap the level restarts from inactive.
// Assumes: at the wrap the staged settings become the ones in force, so
// matches for pixel 0 use the staged copy.
module hblk_blank_gen
    import hblk_pkg::*;
#(
    parameter int unsigned CNT_W   = 10,
    parameter int unsigned NUM_TOG = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ph,
    input  logic                          line_end,
    input  logic [CNT_W-1:0]              cnt_nxt,
    input  logic [NUM_TOG-1:0][CNT_W-1:0] stg_pos,
    input  logic [CNT_W-1:0]              stg_len,
    input  logic [NUM_TOG-1:0][CNT_W-1:0] act_pos,
    input  logic [CNT_W-1:0]              act_len,
    output logic                          blank_q,
    output logic                          restart
);

    logic [CNT_W-1:0]   len_sel;
    logic [CNT_W-1:0]   len_eff;
    logic [NUM_TOG-1:0] hit;
    logic               blank_nxt;

    // Pick the settings that govern the coming pixel.
    always_comb begin
        len_sel = line_end ? stg_len : act_len;
        len_eff = (len_sel < CNT_W'(MIN_LINE)) ? CNT_W'(MIN_LINE) : len_sel;
    end

    // One comparator per toggle slot; slots out of range never hit.
    for (genvar k = 0; k < NUM_TOG; k++) begin : g_hit
        logic [CNT_W-1:0] pos_sel;
        assign pos_sel = line_end ? stg_pos[k] : act_pos[k];
        assign hit[k]  = (pos_sel == cnt_nxt) && (pos_sel < len_eff) && (pos_sel != '1);
    end

    // Next level: restart at the wrap, otherwise invert on an odd hit count.
    always_comb begin
        blank_nxt = line_end ? (^hit) : (blank_q ^ (^hit));
        restart   = ph && blank_nxt && (line_end || !blank_q);
    end

    // Hold the blanking level for a whole pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)  blank_q <= 1'b0;
        else if (ph) blank_q <= blank_nxt;
    end

endmodule

// File: rtl/hblk_hclk_div.sv
// Horizontal shift clocks with optional slowdown during blanking.
// Outside blanking the odd clock follows the half-pixel phase; inside
// blanking with code n it is low n pixels then high n pixels.
// Assumes: restart pulses on the tick before the first pixel of a pulse
// or of a line that starts blanked.
module hblk_hclk_div #(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph,
    input  logic              restart,
    input  logic              blank_q,
    input  logic [CODE_W-1:0] act_code,
    output logic              h13,
    output logic              h24
);

    localparam int unsigned DCNT_W = CODE_W + 1;

    logic [DCNT_W-1:0] dcnt;
    logic [DCNT_W-1:0] dcnt_last;
    logic              slow;

    // Last pixel index of one divided period (2n - 1).
    always_comb dcnt_last = {act_code, 1'b0} - DCNT_W'(1);

    // Count pixels inside blanking, wrapping every 2n pixels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dcnt <= '0;
        else if (ph) begin
            if (restart || act_code == '0) dcnt <= '0;
            else if (blank_q)              dcnt <= (dcnt == dcnt_last) ? '0 : dcnt + 1'b1;
        end
    end

    // Select the divided or pixel-rate waveform.
    always_comb begin
        slow = blank_q && (act_code != '0);
        h13  = slow ? (dcnt >= {1'b0, act_code}) : ph;
        h24  = ~h13;
    end

endmodule

// File: rtl/hclk_blank_gen.sv
// Top of the horizontal shift clock and blanking generator.
// Wires the setting registers, the pixel timer, the blanking former and
// the shift-clock divider together.
// Assumes: clk is twice the pixel rate; rst_n is synchronous.
module hclk_blank_gen #(
    parameter int unsigned CNT_W   = 10,
    parameter int unsigned NUM_TOG = 6,
    parameter int unsigned CODE_W  = 3,
    parameter int unsigned DEF_LEN = 16,
    parameter int unsigned ADDR_W  = $clog2(NUM_TOG + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_wdata,
    output logic              hblank_o,
    output logic              h13_o,
    output logic              h24_o
);

    logic [NUM_TOG-1:0][CNT_W-1:0] stg_pos;
    logic [NUM_TOG-1:0][CNT_W-1:0] act_pos;
    logic [CNT_W-1:0]              stg_len;
    logic [CNT_W-1:0]              act_len;
    logic [CODE_W-1:0]             act_code;
    logic                          ph;
    logic [CNT_W-1:0]              pix_cnt;
    logic [CNT_W-1:0]              pix_nxt;
    logic                          line_end;
    logic                          restart;

    hblk_cfg_regs #(
        .CNT_W(CNT_W), .NUM_TOG(NUM_TOG), .CODE_W(CODE_W),
        .DEF_LEN(DEF_LEN), .ADDR_W(ADDR_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .load(line_end),
        .stg_pos(stg_pos), .stg_len(stg_len),
        .act_pos(act_pos), .act_len(act_len), .act_code(act_code)
    );

    hblk_pix_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .act_len(act_len),
        .ph(ph), .cnt(pix_cnt), .cnt_nxt(pix_nxt), .line_end(line_end)
    );

    hblk_blank_gen #(.CNT_W(CNT_W), .NUM_TOG(NUM_TOG)) blank_i (
        .clk(clk), .rst_n(rst_n), .ph(ph), .line_end(line_end),
        .cnt_nxt(pix_nxt), .stg_pos(stg_pos), .stg_len(stg_len),
        .act_pos(act_pos), .act_len(act_len),
        .blank_q(hblank_o), .restart(restart)
    );

    hblk_hclk_div #(.CODE_W(CODE_W)) div_i (
        .clk(clk), .rst_n(rst_n), .ph(ph), .restart(restart),
        .blank_q(hblank_o), .act_code(act_code),
        .h13(h13_o), .h24(h24_o)
    );

endmodule

// File: rtl/hblk_checker.sv
// Timing properties of the generator, bound to the top module.
module hblk_checker #(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blank,
    input logic              h13,
    input logic              h24,
    input logic              ph,
    input logic [CNT_W-1:0]  pix_cnt,
    input logic [CNT_W-1:0]  act_len,
    input logic [CODE_W-1:0] act_code
);

    logic past_ok;

    // Mark cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: a reset edge leaves the idle output levels.
    a_r1_reset_levels: assert property (@(posedge clk)
        !rst_n |=> (!blank && !h13 && h24));

    // R2: the pixel counter stays inside the effective line.
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (pix_cnt < ((act_len < CNT_W'(2)) ? CNT_W'(2) : act_len)));

    // R3: the blanking level only changes at a pixel boundary.
    a_r3_pixel_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && blank != $past(blank)) |-> !ph);

    // R7: outside blanking the odd clock flips on every tick.
    a_r7_pixel_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !blank && !$past(blank) && $past(rst_n)) |-> (h13 != $past(h13)));

    // R8: a slowed clock holds its level through both halves of a pixel.
    a_r8_hold_in_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ph && blank && $past(blank) && act_code != '0) |-> $stable(h13));

endmodule

bind hclk_blank_gen hblk_checker #(.CNT_W(CNT_W), .CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .blank(hblank_o), .h13(h13_o), .h24(h24_o),
    .ph(ph), .pix_cnt(pix_cnt), .act_len(act_len), .act_code(act_code)
);

// File: tb/hclk_blank_gen_tb_top.sv
module hclk_blank_gen_tb_top;

    localparam int CNT_W   = 10;
    localparam int NUM_TOG = 6;
    localparam int CODE_W  = 3;
    localparam int DEF_LEN = 16;
    localparam int ADDR_W  = 3;
    localparam int SENT    = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [CNT_W-1:0]  cfg_wdata = '0;
    logic              hblank_o, h13_o, h24_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string cur_tag = "";

    // Line model state
    int m_pix, m_ph;
    int a_pos[NUM_TOG];
    int s_pos[NUM_TOG];
    int a_len, s_len, a_code, s_code;

    always #5 clk = ~clk;

    hclk_blank_gen #(.CNT_W(CNT_W), .NUM_TOG(NUM_TOG), .CODE_W(CODE_W),
                     .DEF_LEN(DEF_LEN), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hblank_o(hblank_o), .h13_o(h13_o), .h24_o(h24_o)
    );

    function automatic int effl(int l);
        return (l < 2) ? 2 : l;
    endfunction

    // R3/R4: parity of in-range positions at or before pixel c.
    function automatic bit exp_blank_at(int c);
        bit b = 1'b0;
        for (int k = 0; k < NUM_TOG; k++)
            if (a_pos[k] < effl(a_len) && a_pos[k] != SENT && a_pos[k] <= c) b = ~b;
        return b;
    endfunction

    // R7/R8: expected odd shift clock for the current tick.
    function automatic bit exp_h13();
        int b, d;
        if (exp_blank_at(m_pix) && a_code != 0) begin
            b = m_pix;
            while (b > 0 && exp_blank_at(b - 1)) b--;
            d = (m_pix - b) % (2 * a_code);
            return d >= a_code;
        end
        return m_ph[0];
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NUM_TOG; k++) begin a_pos[k] = SENT; s_pos[k] = SENT; end
        a_len = DEF_LEN; s_len = DEF_LEN; a_code = 0; s_code = 0;
        m_pix = 0; m_ph = 0;
    endtask

    task automatic chk(string tag, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s pix=%0d half=%0d actual=%0b expected=%0b",
                     tag, m_pix, m_ph, act, exp);
        end
    endtask

    // One clock: advance the model at the edge, compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            if (m_ph == 1) begin
                if (m_pix == effl(a_len) - 1) begin
                    a_pos = s_pos; a_len = s_len; a_code = s_code; // R9 line-start load
                    m_pix = 0;
                end else m_pix++;
                m_ph = 0;
            end else m_ph = 1;
            if (cfg_we) begin
                if (cfg_addr < NUM_TOG) s_pos[cfg_addr] = int'(cfg_wdata);
                else if (cfg_addr == NUM_TOG) s_len = int'(cfg_wdata);
                else s_code = int'(cfg_wdata[CODE_W-1:0]);
            end
        end
        @(negedge clk);
        if (!rst_n) begin
            chk("R1 blank", hblank_o, 1'b0);
            chk("R1 h13", h13_o, 1'b0);
            chk("R1 h24", h24_o, 1'b1);
        end else begin
            chk({"R3 blank ", cur_tag}, hblank_o, exp_blank_at(m_pix));
            chk({(exp_blank_at(m_pix) && a_code != 0) ? "R8 h13 " : "R7 h13 ", cur_tag},
                h13_o, exp_h13());
            chk({"R6 h24 ", cur_tag}, h24_o, ~h13_o);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // R9: write one setting through the port.
    task automatic wr(int a, int d);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = CNT_W'(d);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic setup(int len, int code, int p0, int p1, int p2, int p3, int p4, int p5);
        wr(0, p0); wr(1, p1); wr(2, p2); wr(3, p3); wr(4, p4); wr(5, p5);
        wr(6, len); wr(7, code);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        cur_tag = "R1";
        run(3);
        @(negedge clk) rst_n = 1'b1;
        run(4);

        // R9: settings written mid-line wait for the next line start.
        cur_tag = "R9";
        setup(12, 1, 0, 3, 5, 9, SENT, SENT);
        run(2 * 16 + 4 * 12);

        // R4: out-of-range, sentinel and duplicate positions.
        cur_tag = "R4";
        setup(12, 2, 20, SENT, 4, 4, 2, 12);
        run(2 * 12 + 4 * 12);

        // R2: lengths below the minimum behave as two pixels.
        cur_tag = "R2";
        setup(0, 0, 1, SENT, SENT, SENT, SENT, SENT);
        run(2 * 12 + 16);
        setup(1, 3, 0, SENT, SENT, SENT, SENT, SENT);
        run(16);

        // R8: slowest rate over a long pulse.
        cur_tag = "R8";
        setup(50, 7, 2, 41, SENT, SENT, SENT, SENT);
        run(2 * 4 + 4 * 50);

        // R5: pulse running through the wrap into pixel 0.
        cur_tag = "R5";
        setup(20, 3, 0, 7, 15, SENT, SENT, SENT);
        run(2 * 50 + 4 * 20);

        // Random lines
        for (int s = 0; s < 25; s++) begin
            int len, p[NUM_TOG];
            cur_tag = "rand";
            len = 4 + int'($urandom_range(56));
            for (int k = 0; k < NUM_TOG; k++)
                p[k] = ($urandom_range(3) == 0) ? SENT : int'($urandom_range(len + 5));
            setup(len, int'($urandom_range(7)), p[0], p[1], p[2], p[3], p[4], p[5]);
            run(2 * 64 + 4 * len);
        end

        // R1: reset during operation clears the settings.
        cur_tag = "R1";
        @(negedge clk) rst_n = 1'b0;
        run(2);
        @(negedge clk) rst_n = 1'b1;
        cur_tag = "R1 after";
        run(4 * DEF_LEN);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule